// File: doc/BRIEF.md
# Single/double-length shift unit

The unit carries out shift operations on a 24-bit accumulator and its 24-bit extension. It works either on the accumulator alone or on the pair joined as one 48-bit value, and it moves one bit position per clock. A start strobe loads the operands, a 4-bit operation code and a shift count. An index value can be added to the count. The unit then iterates until the count is used up. When it finishes, the shifted values appear on the outputs and a one-cycle done pulse is raised.

A normalize operation shifts the joined pair left until the top two accumulator bits differ, or until the count is used up. The number of positions it actually moved is presented with a write strobe, so that the surrounding core can store it in its index register 0. Every accepted operation also reports an execution-time figure, in machine cycles, that follows a stepped rule.

Top module: `shift_unit`

## Requirements
- R1: After reset, a_o and e_o are zero, and busy_o, done_o and norm_we_o are low.
- R2: The effective count is count_i plus idx_i (modulo 2^14) when idx_en_i is high; when idx_en_i is low, idx_i has no effect. The unit is captured by the edge at which start_i is sampled high while idle, and busy_o rises there. It shifts one position at each following edge. done_o is high for exactly one cycle, the cycle after the last step, so an operation of s steps ends with done_o set by the (s+1)-th edge after the capturing edge.
- R3: Arithmetic right (single code 4'o10 and double code 4'o14) keeps A[23] fixed and copies it into A[22] on each step. The bit leaving A[0] is lost in single form. In double form it enters E[23], and the bit leaving E[0] is lost.
- R4: Logical right (single code 4'o11 and double code 4'o15) enters a zero at A[23]. In double form, A[0] enters E[23] and the bit leaving E[0] is lost.
- R5: Rotate left single (4'o12) moves A[23] into A[0]. Rotate left double (4'o16) moves A[23] into E[0] and E[23] into A[0].
- R6: Left end-off (single code 4'o13 and double code 4'o17) enters zeros at the low end. In double form, E[23] feeds A[0], a zero enters E[0], and the bit leaving A[23] is discarded.
- R7: Normalize (4'o07) shifts like a double left end-off. Before each step it stops if the count is used up or if A[23] differs from A[22]. A count of 0, or an already normalized A, gives 0 steps.
- R8: norm_we_o is high only in the done_o cycle of a normalize operation. In that cycle, norm_cnt_o equals the number of positions actually shifted.
- R9: cycles_o, valid with done_o, is 2 for effective counts up to 9. It rises by one for each further started group of 5 positions (10-14 give 3, 15-19 give 4).
- R10: Counts larger than the operand width are iterated in full. Right shifts end as all sign copies or all zeros, end-off shifts as zeros, and rotates as a rotation modulo 24 (single) or 48 (double).
- R11: Single-length operations leave the extension unchanged: e_o at done equals the E value captured at start.
- R12: A start with an operation code below 4'o07, or a start while busy_o is high, is ignored. No operation begins, no done_o follows, and a_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| aug_i | input | 4 | Operation code |
| count_i | input | 6 | Immediate shift count |
| idx_en_i | input | 1 | Add idx_i to the count |
| idx_i | input | 14 | Index value added to the count |
| a_i | input | 24 | Accumulator operand |
| e_i | input | 24 | Extension operand |
| a_o | output | 24 | Working/result accumulator |
| e_o | output | 24 | Working/result extension |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| norm_cnt_o | output | 14 | Positions shifted by normalize |
| norm_we_o | output | 1 | Write strobe for norm_cnt_o |
| cycles_o | output | 12 | Execution-time figure of the operation |

## Verification
The two termination conditions of normalize can fall in the same cycle: the count runs out on the very step that makes A[23] and A[22] differ. This is provoked with an accumulator whose leading one lies exactly count positions below bit 22, for example 24'h001000 with a count of 10. The result is judged on the final A:E, on norm_cnt_o equal to the count, and on done_o arriving exactly one edge after the last step. That done_o timing would shift by one if either condition were handled as an extra cycle. The neighbouring cases, one where the early stop wins and one where an already normalized operand reports zero, are run against the same scoreboard.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [3:0] {
    OP_NORM = 4'o07,
    OP_ARS1 = 4'o10,
    OP_LRS1 = 4'o11,
    OP_ROL1 = 4'o12,
    OP_LEO1 = 4'o13,
    OP_ARS2 = 4'o14,
    OP_LRS2 = 4'o15,
    OP_ROL2 = 4'o16,
    OP_LEO2 = 4'o17
  } shift_op_e;

  localparam logic [3:0] OP_FIRST = 4'o07;
endpackage

// File: rtl/shift_step.sv
module shift_step
  import shift_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  shift_op_e         op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] e_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] e_o
);
  always_comb begin
    a_o = a_i;
    e_o = e_i;
    unique case (op_i)
      OP_ARS1: a_o = {a_i[DATA_W-1], a_i[DATA_W-1:1]};
      OP_LRS1: a_o = {1'b0, a_i[DATA_W-1:1]};
      OP_ROL1: a_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      OP_LEO1: a_o = {a_i[DATA_W-2:0], 1'b0};
      OP_ARS2: begin
        a_o = {a_i[DATA_W-1], a_i[DATA_W-1:1]};
        e_o = {a_i[0], e_i[DATA_W-1:1]};
      end
      OP_LRS2: begin
        a_o = {1'b0, a_i[DATA_W-1:1]};
        e_o = {a_i[0], e_i[DATA_W-1:1]};
      end
      OP_ROL2: begin
        a_o = {a_i[DATA_W-2:0], e_i[DATA_W-1]};
        e_o = {e_i[DATA_W-2:0], a_i[DATA_W-1]};
      end
      OP_LEO2, OP_NORM: begin
        a_o = {a_i[DATA_W-2:0], e_i[DATA_W-1]};
        e_o = {e_i[DATA_W-2:0], 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shift_timing.sv
module shift_timing #(
  parameter int CNT_W = 14,
  parameter int CYC_W = 12,
  parameter int BASE_MAX = 9,
  parameter int GROUP = 5
) (
  input  logic [CNT_W-1:0] n_i,
  output logic [CYC_W-1:0] cyc_o
);
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(BASE_MAX);
  localparam logic [CNT_W-1:0] GRP  = CNT_W'(GROUP);
  localparam logic [CNT_W-1:0] BIAS = CNT_W'(BASE_MAX + 1 - GROUP);

  logic [CNT_W-1:0] groups;

  always_comb begin
    groups = (n_i - BIAS) / GRP;
    if (n_i <= LIM) cyc_o = CYC_W'(2);
    else            cyc_o = CYC_W'(2) + CYC_W'(groups);
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SCNT_W = 6,
  parameter int CNT_W  = 14,
  parameter int CYC_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        aug_i,
  input  logic [SCNT_W-1:0] count_i,
  input  logic              idx_en_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] e_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] e_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  norm_cnt_o,
  output logic              norm_we_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam int TOP = DATA_W - 1;

  shift_op_e         op_q;
  logic              busy_q, done_q, we_q;
  logic [DATA_W-1:0] a_q, e_q, a_nx, e_nx;
  logic [CNT_W-1:0]  rem_q, cnt_q, n_eff;
  logic [CYC_W-1:0]  cyc_q, cyc_nx;
  logic              op_ok, accept, stop, is_norm, is_single;

  assign op_ok  = (aug_i >= OP_FIRST);
  assign accept = start_i && op_ok && !busy_q;
  assign n_eff  = CNT_W'(count_i) + (idx_en_i ? idx_i : '0);

  assign is_norm   = (op_q == OP_NORM);
  assign is_single = !is_norm && !op_q[2];
  assign stop = (rem_q == '0) || (is_norm && (a_q[TOP] != a_q[TOP-1]));

  shift_step #(.DATA_W(DATA_W)) i_step (
    .op_i(op_q), .a_i(a_q), .e_i(e_q), .a_o(a_nx), .e_o(e_nx)
  );

  shift_timing #(.CNT_W(CNT_W), .CYC_W(CYC_W)) i_timing (
    .n_i(n_eff), .cyc_o(cyc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      we_q   <= 1'b0;
      op_q   <= OP_NORM;
      a_q    <= '0;
      e_q    <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      cyc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      if (!busy_q) begin
        if (accept) begin
          busy_q <= 1'b1;
          op_q   <= shift_op_e'(aug_i);
          a_q    <= a_i;
          e_q    <= e_i;
          rem_q  <= n_eff;
          cnt_q  <= '0;
          cyc_q  <= cyc_nx;
        end
      end else if (stop) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        we_q   <= is_norm;
      end else begin
        a_q   <= a_nx;
        e_q   <= e_nx;
        rem_q <= rem_q - 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign a_o        = a_q;
  assign e_o        = e_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign norm_we_o  = we_q;
  assign norm_cnt_o = cnt_q;
  assign cycles_o   = cyc_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_step_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !stop) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_sign_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (op_q == OP_ARS1 || op_q == OP_ARS2)) |=> $stable(a_q[TOP]));

  p_norm_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_we_o && rem_q != '0) |-> (a_o[TOP] != a_o[TOP-1]));

  p_norm_we_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_we_o |-> (done_o && op_q == OP_NORM));

  p_cycles_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o >= CYC_W'(2)));

  p_single_e_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && is_single) |=> $stable(e_q));

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !(start_i && op_ok)) |=> (!busy_q && $stable(a_q)));
endmodule

// File: tb/test_shift_unit.sv
module test_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  aug_i = '0;
  logic [5:0]  count_i = '0;
  logic        idx_en_i = 1'b0;
  logic [13:0] idx_i = '0;
  logic [23:0] a_i = '0, e_i = '0;
  logic [23:0] a_o, e_o;
  logic        busy_o, done_o, norm_we_o;
  logic [13:0] norm_cnt_o;
  logic [11:0] cycles_o;

  shift_unit i_shift_unit (
    .clk_i, .rst_ni, .start_i, .aug_i, .count_i, .idx_en_i, .idx_i,
    .a_i, .e_i, .a_o, .e_o, .busy_o, .done_o, .norm_cnt_o, .norm_we_o,
    .cycles_o
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [23:0] a, e;
    logic        we;
    logic [13:0] nc;
    logic [11:0] cyc;
    int          lat;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   tracking = 0;
  int   lat_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model(input logic [3:0] op, input int n, input logic [23:0] a0,
                       input logic [23:0] e0, output logic [23:0] ra,
                       output logic [23:0] re, output int steps);
    logic [23:0] a, e, ta;
    a = a0; e = e0; steps = 0;
    for (int i = 0; i < n; i++) begin
      if (op == 4'o07 && a[23] != a[22]) break;
      ta = a;
      case (op)
        4'o10: a = {a[23], a[23:1]};
        4'o11: a = a >> 1;
        4'o12: a = {a[22:0], a[23]};
        4'o13: a = a << 1;
        4'o14: begin a = {a[23], a[23:1]}; e = {ta[0], e[23:1]}; end
        4'o15: begin a = a >> 1; e = {ta[0], e[23:1]}; end
        4'o16: begin a = {a[22:0], e[23]}; e = {e[22:0], ta[23]}; end
        default: begin a = {a[22:0], e[23]}; e = e << 1; end
      endcase
      steps++;
    end
    ra = a; re = e;
  endtask

  function automatic int cyc_rule(input int n);
    int c = 2;
    for (int r = n - 9; r > 0; r -= 5) c++;
    return c;
  endfunction

  task automatic pulse(input logic [3:0] op, input int cnt, input bit ie,
                       input int idx, input logic [23:0] a, input logic [23:0] e);
    @(posedge clk_i); #1;
    start_i = 1; aug_i = op; count_i = 6'(cnt); idx_en_i = ie; idx_i = 14'(idx);
    a_i = a; e_i = e;
    @(posedge clk_i); #1;
    start_i = 0;
  endtask

  task automatic push(input string tag, input logic [3:0] op, input int cnt,
                      input bit ie, input int idx, input logic [23:0] a,
                      input logic [23:0] e);
    exp_t x;
    int n, s;
    n = ie ? ((cnt + idx) % 16384) : cnt;
    model(op, n, a, e, x.a, x.e, s);
    x.we = (op == 4'o07);
    x.nc = 14'(s);
    x.cyc = 12'(cyc_rule(n));
    x.lat = s + 2;
    x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic run(input string tag, input logic [3:0] op, input int cnt,
                     input bit ie, input int idx, input logic [23:0] a,
                     input logic [23:0] e);
    push(tag, op, cnt, ie, idx, a, e);
    pulse(op, cnt, ie, idx, a, e);
    do @(negedge clk_i); while (!done_o);
  endtask

  // monitor
  initial begin
    exp_t x;
    forever begin
      @(negedge clk_i);
      if (tracking) lat_cnt++;
      if (rst_ni && start_i && !busy_o && aug_i >= 4'o07) begin
        tracking = 1; lat_cnt = 0;
      end
      if (done_o) begin
        tracking = 0;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R12 unexpected done actual=1 expected=0");
        end else begin
          x = exp_q.pop_front();
          chk({x.tag, " a"}, 32'(a_o), 32'(x.a));
          chk({x.tag, " e"}, 32'(e_o), 32'(x.e));
          chk({x.tag, " R8 we"}, 32'(norm_we_o), 32'(x.we));
          if (x.we) chk({x.tag, " R8 ncnt"}, 32'(norm_cnt_o), 32'(x.nc));
          chk({x.tag, " R9 cycles"}, 32'(cycles_o), 32'(x.cyc));
          chk({x.tag, " R2 latency"}, 32'(lat_cnt), 32'(x.lat));
        end
      end
    end
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    #23;
    chk("R1 a_o", 32'(a_o), 0);
    chk("R1 e_o", 32'(e_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 we", 32'(norm_we_o), 0);
    rst_ni = 1;

    run("R3 ars1", 4'o10, 4, 0, 0, 24'h800F00, 24'h123456);
    run("R3 ars2", 4'o14, 8, 0, 0, 24'h8000A5, 24'h00FF00);
    run("R4 lrs1", 4'o11, 5, 0, 0, 24'hF0F0F0, 24'hABCDEF);
    run("R4 lrs2", 4'o15, 26, 0, 0, 24'hC00003, 24'h5A5A5A);
    run("R5 rol1", 4'o12, 3, 0, 0, 24'hA00001, 24'h777777);
    run("R5 rol2", 4'o16, 13, 0, 0, 24'h80FF01, 24'h400002);
    run("R6 leo1", 4'o13, 7, 0, 0, 24'hFFFFFF, 24'h111111);
    run("R6 leo2", 4'o17, 30, 0, 0, 24'h123456, 24'hF00001);
    run("R7 norm early", 4'o07, 40, 0, 0, 24'h000F00, 24'hABCDEF);
    run("R7 norm neg", 4'o07, 20, 0, 0, 24'hFFF000, 24'h800000);
    run("R7 norm zero cnt", 4'o07, 0, 0, 0, 24'h000001, 24'h000001);
    run("R7 norm prenorm", 4'o07, 5, 0, 0, 24'h400000, 24'hFFFFFF);
    run("R7 norm coincide", 4'o07, 10, 0, 0, 24'h001000, 24'h000000);
    run("R2 index add", 4'o13, 3, 1, 5, 24'h000001, 24'h0);
    run("R2 index off", 4'o13, 3, 0, 7, 24'h000001, 24'h0);
    run("R9 n9", 4'o11, 9, 0, 0, 24'hFFFFFF, 24'h0);
    run("R9 n10", 4'o11, 10, 0, 0, 24'hFFFFFF, 24'h0);
    run("R9 n14", 4'o11, 14, 0, 0, 24'hFFFFFF, 24'h0);
    run("R9 n15", 4'o11, 15, 0, 0, 24'hFFFFFF, 24'h0);
    run("R10 ars1 sat", 4'o10, 30, 0, 0, 24'h812345, 24'h0);
    run("R10 rol1 mod24", 4'o12, 24, 0, 0, 24'h9ABCDE, 24'h0);
    run("R10 rol2 mod48", 4'o16, 50, 0, 0, 24'h800001, 24'h000003);
    run("R10 lrs2 sat", 4'o15, 20, 1, 40, 24'hFFFFFF, 24'hFFFFFF);
    run("R11 single e", 4'o13, 6, 0, 0, 24'h00000F, 24'hC3C3C3);

    // R12: code below 7 ignored
    @(posedge clk_i); #1;
    held = a_o;
    pulse(4'o03, 5, 0, 0, 24'h5555AA, 24'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R12 bad code busy", 32'(busy_o), 0);
    end
    chk("R12 bad code a_o", 32'(a_o), 32'(held));

    // R12: start while busy ignored
    push("R12 busy start", 4'o10, 20, 0, 0, 24'h80F00F, 24'h123123);
    pulse(4'o10, 20, 0, 0, 24'h80F00F, 24'h123123);
    repeat (3) @(posedge clk_i);
    #1;
    start_i = 1; aug_i = 4'o11; count_i = 6'd2; a_i = 24'h0F0F0F; e_i = 24'h0;
    @(posedge clk_i); #1;
    start_i = 0;
    do @(negedge clk_i); while (!done_o);
    repeat (3) begin
      @(negedge clk_i);
      chk("R12 no second op", 32'(busy_o), 0);
    end

    repeat (2) @(negedge clk_i);
    chk("queue drained", 32'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule